// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Paired-Byte Nine-Bit Mode

This block turns bytes pulled from a transmit FIFO into asynchronous serial frames on one output line. Each frame is a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The character can be 7 or 8 bits wide with or without parity, or 9 bits wide with parity always off. The timing of every bit comes from an external baud tick that pulses for one clock cycle per bit period.

Two FIFO bytes can form one 9-bit character. With the paired mode on and a 9-bit length selected, the first byte popped gives data bits 7..0 and bit 0 of the second byte gives data bit 8. The frame does not begin until that second byte has been popped. Without the paired mode, a 9-bit character uses a single byte and its ninth bit is sent as 0. The configuration is sampled when the first byte of a character is popped and holds until that character ends.

The FIFO is read in show-ahead fashion: `fifoData` is valid whenever `fifoEmpty` is low, and a pulse on `fifoRead` pops the word on the same clock edge.

Top module: `uart_wide_tx`

## Requirements
- R1: After reset `txOut` is 1 and `busy` is 0; while idle the line stays 1 and `fifoRead` is never asserted while `fifoEmpty` is 1.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits at 1. `txOut` only changes in the cycle after a `baudTick` pulse, and each bit lasts exactly one tick interval.
- R3: `cfgLen` encoding: 0 selects 8 data bits, 1 selects 7, 2 selects 9 and 3 selects 8. An all-zero configuration gives 8 data bits, no parity and one stop bit.
- R4: With `cfgParEn`=1 and a 7 or 8 bit length, a parity bit is sent, computed over the configured data bits only. `cfgParType` 0 = odd, 1 = even, 2 = always 1, 3 = always 0. With a 9-bit length no parity bit is sent, whatever `cfgParEn` is.
- R5: `cfgStop2`=0 sends one stop bit and `cfgStop2`=1 sends two.
- R6: With a 9-bit length and `cfgWide`=0, each character takes one FIFO byte and its data bit 8 is 0.
- R7: With a 9-bit length and `cfgWide`=1, the first popped byte gives data bits 7..0 and bit 0 of the second gives data bit 8. Bits 7..1 of the second byte have no effect on the line.
- R8: In the paired mode, after the first byte is popped and while the FIFO is empty, `txOut` stays 1 and `busy` stays 1 until the second byte arrives.
- R9: With `cfgWide`=1 and a 7 or 8 bit length, each character takes one byte, exactly as with `cfgWide`=0.
- R10: A new character is popped only when the transmitter is idle, which includes right after the last stop bit of the previous character. Queued bytes go out back to back, with the next start bit at the first tick after the previous frame ends.
- R11: `busy` rises in the cycle after the first byte of a character is popped. It falls after the last stop bit has lasted its full tick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoData | input | 8 | Head word of the transmit FIFO (show-ahead) |
| fifoEmpty | input | 1 | FIFO has no word |
| fifoRead | output | 1 | Pops the head word at this clock edge |
| cfgLen | input | 2 | Character length select (R3) |
| cfgParEn | input | 1 | Parity enable |
| cfgParType | input | 2 | Parity type (R4) |
| cfgStop2 | input | 1 | Two stop bits when 1 |
| cfgWide | input | 1 | Build 9-bit characters from byte pairs |
| baudTick | input | 1 | One-cycle pulse per bit period |
| txOut | output | 1 | Serial line, idles high |
| busy | output | 1 | A character is in progress |

## Verification
The assertions assume that `baudTick` is a single-cycle pulse, that the FIFO flags follow show-ahead rules, and that the configuration inputs do not change while `busy` is high. The bench generates the tick from a fixed counter with a period of several clocks. It models the FIFO as a queue whose head and empty flag change only at the falling clock edge, after a pop. It changes the configuration, randomly or in directed cases, only after `busy` has been seen low.

// File: rtl/uart_wide_tx_pkg.sv
package uart_wide_tx_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAX_DATA = BYTE_W + 1;
  localparam int FRAME_W  = 1 + BYTE_W + 1 + 2;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAIR = 2'd1,
    ST_SEND = 2'd2
  } txState_e;

  typedef struct packed {
    logic latchFirst;
    logic buildFrame;
    logic fromPair;
    logic emitBit;
    logic endFrame;
  } txStrobes_t;
endpackage

// File: rtl/uart_wide_tx_datapath.sv
module uart_wide_tx_datapath
  import uart_wide_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [BYTE_W-1:0] fifoData,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic [1:0]        cfgParType,
  input  logic              cfgStop2,
  output logic              cntZero,
  output logic              txOut
);
  logic [BYTE_W-1:0] heldByte;
  logic [1:0]        heldLen;
  logic              heldParEn;
  logic [1:0]        heldParType;
  logic              heldStop2;

  logic [FRAME_W-1:0] frameReg;
  logic [CNT_W-1:0]   bitsLeft;
  logic               txLine;

  logic [1:0]          useLen;
  logic                useParEn;
  logic [1:0]          useParType;
  logic                useStop2;
  logic [MAX_DATA-1:0] dataWord;
  logic [MAX_DATA-1:0] dataMask;
  int                  nBits;
  logic                parOn;
  logic                parBit;
  logic                rawXor;
  logic [FRAME_W-1:0]  newFrame;
  logic [CNT_W-1:0]    newCount;

  always_comb begin
    useLen      = strobes.fromPair ? heldLen     : cfgLen;
    useParEn    = strobes.fromPair ? heldParEn   : cfgParEn;
    useParType  = strobes.fromPair ? heldParType : cfgParType;
    useStop2    = strobes.fromPair ? heldStop2   : cfgStop2;
    dataWord    = strobes.fromPair ? {fifoData[0], heldByte} : {1'b0, fifoData};
    case (useLen)
      2'd1:    nBits = MAX_DATA - 2;
      2'd2:    nBits = MAX_DATA;
      default: nBits = MAX_DATA - 1;
    endcase
    parOn = useParEn && (nBits != MAX_DATA);
    for (int i = 0; i < MAX_DATA; i++) dataMask[i] = (i < nBits);
    rawXor = ^(dataWord & dataMask);
    case (useParType)
      2'd0:    parBit = ~rawXor;
      2'd1:    parBit = rawXor;
      2'd2:    parBit = 1'b1;
      default: parBit = 1'b0;
    endcase
    newFrame    = '1;
    newFrame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < nBits) newFrame[i+1] = dataWord[i];
    if (parOn) newFrame[nBits+1] = parBit;
    newCount = CNT_W'(2 + nBits + int'(parOn) + int'(useStop2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldByte    <= '0;
      heldLen     <= '0;
      heldParEn   <= 1'b0;
      heldParType <= '0;
      heldStop2   <= 1'b0;
    end else if (strobes.latchFirst) begin
      heldByte    <= fifoData;
      heldLen     <= cfgLen;
      heldParEn   <= cfgParEn;
      heldParType <= cfgParType;
      heldStop2   <= cfgStop2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
      bitsLeft <= '0;
      txLine   <= 1'b1;
    end else if (strobes.buildFrame) begin
      frameReg <= newFrame;
      bitsLeft <= newCount;
    end else if (strobes.emitBit) begin
      txLine   <= frameReg[0];
      frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - 1'b1;
    end else if (strobes.endFrame) begin
      txLine   <= 1'b1;
    end
  end

  assign cntZero = (bitsLeft == '0);
  assign txOut   = txLine;

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= CNT_W'(FRAME_W));
  assert_no_emit_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emitBit |-> !cntZero);
endmodule

// File: rtl/uart_wide_tx_control.sv
module uart_wide_tx_control
  import uart_wide_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEmpty,
  input  logic [1:0] cfgLen,
  input  logic       cfgWide,
  input  logic       baudTick,
  input  logic       cntZero,
  output logic       fifoRead,
  output txStrobes_t strobes,
  output logic       busy
);
  txState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    fifoRead  = 1'b0;
    case (state)
      ST_IDLE: if (!fifoEmpty) begin
        fifoRead = 1'b1;
        if (cfgWide && cfgLen == 2'd2) begin
          strobes.latchFirst = 1'b1;
          stateNext = ST_PAIR;
        end else begin
          strobes.buildFrame = 1'b1;
          stateNext = ST_SEND;
        end
      end
      ST_PAIR: if (!fifoEmpty) begin
        fifoRead           = 1'b1;
        strobes.buildFrame = 1'b1;
        strobes.fromPair   = 1'b1;
        stateNext          = ST_SEND;
      end
      ST_SEND: if (baudTick) begin
        if (cntZero) begin
          strobes.endFrame = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobes.emitBit = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  assert_no_read_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |-> !fifoEmpty);
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(fifoRead));
  assert_pair_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAIR && fifoEmpty) |=> (state == ST_PAIR));
  assert_read_when_free_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRead && state == ST_IDLE) |=> busy);
endmodule

// File: rtl/uart_wide_tx.sv
module uart_wide_tx
  import uart_wide_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              fifoRead,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic [1:0]        cfgParType,
  input  logic              cfgStop2,
  input  logic              cfgWide,
  input  logic              baudTick,
  output logic              txOut,
  output logic              busy
);
  txStrobes_t strobes;
  logic       cntZero;

  uart_wide_tx_control u_control (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .cfgLen(cfgLen),
    .cfgWide(cfgWide), .baudTick(baudTick), .cntZero(cntZero),
    .fifoRead(fifoRead), .strobes(strobes), .busy(busy)
  );

  uart_wide_tx_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fifoData(fifoData),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgParType(cfgParType),
    .cfgStop2(cfgStop2), .cntZero(cntZero), .txOut(txOut)
  );

  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);
  assert_tick_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txOut != $past(txOut)) |-> $past(baudTick));
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!busy) && busy) |-> txOut);
endmodule

// File: tb/uart_wide_tx_bench.sv
`timescale 1ns/1ps
module uart_wide_tx_bench;
  localparam int TICK_P = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] fifoData = 8'h00;
  logic       fifoEmpty = 1'b1;
  logic       fifoRead;
  logic [1:0] cfgLen = 2'd0;
  logic       cfgParEn = 1'b0;
  logic [1:0] cfgParType = 2'd0;
  logic       cfgStop2 = 1'b0;
  logic       cfgWide = 1'b0;
  logic       baudTick = 1'b0;
  logic       txOut;
  logic       busy;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int tickCnt = 0;
  logic popFlag = 1'b0;
  logic [7:0] fifoQ[$];

  always #2.5 clk = ~clk;

  uart_wide_tx u_uart_wide_tx (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoRead(fifoRead), .cfgLen(cfgLen), .cfgParEn(cfgParEn),
    .cfgParType(cfgParType), .cfgStop2(cfgStop2), .cfgWide(cfgWide),
    .baudTick(baudTick), .txOut(txOut), .busy(busy)
  );

  always @(posedge clk) popFlag <= fifoRead;

  always @(negedge clk) begin
    cycles++;
    tickCnt  = (tickCnt + 1) % TICK_P;
    baudTick = (tickCnt == 0);
    if (popFlag && fifoQ.size() > 0) void'(fifoQ.pop_front());
    fifoEmpty = (fifoQ.size() == 0);
    fifoData  = fifoEmpty ? 8'h00 : fifoQ[0];
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int dataLen(input logic [1:0] len);
    return (len == 2'd1) ? 7 : (len == 2'd2) ? 9 : 8;
  endfunction

  // expected frame bits, LSB sent first; returns bit count in nb
  function automatic logic [15:0] expFrame(input logic [1:0] len, input logic pe,
      input logic [1:0] pt, input logic s2, input logic wide,
      input logic [7:0] b0, input logic [7:0] b1, output int nb);
    logic [15:0] f;
    logic [8:0] d;
    logic x;
    int n, p;
    n = dataLen(len);
    d = {(n == 9 && wide) ? b1[0] : 1'b0, b0};
    x = 1'b0;
    for (int i = 0; i < n; i++) x ^= d[i];
    f = '1; f[0] = 1'b0; p = 1;
    for (int i = 0; i < n; i++) begin f[p] = d[i]; p++; end
    if (pe && n != 9) begin
      f[p] = (pt == 2'd0) ? ~x : (pt == 2'd1) ? x : (pt == 2'd2);
      p++;
    end
    nb = p + 1 + int'(s2);
    return f;
  endfunction

  task automatic pushByte(input logic [7:0] b);
    @(posedge clk); #1;
    fifoQ.push_back(b);
  endtask

  task automatic rxFrame(input int nb, output logic [15:0] bits, output bit ok);
    int waitC;
    bits = '1; ok = 1'b0; waitC = 0;
    @(negedge clk);
    while (txOut !== 1'b0 && waitC < 400) begin @(negedge clk); waitC++; end
    if (txOut !== 1'b0) return;
    ok = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      bits[i] = txOut;
      if (i < nb - 1) repeat (TICK_P) @(negedge clk);
    end
  endtask

  task automatic waitIdle(input string tag);
    int waitC = 0;
    while (busy !== 1'b0 && waitC < 400) begin @(negedge clk); waitC++; end
    check(busy === 1'b0 && txOut === 1'b1, tag, {14'd0, busy, txOut}, 16'h0001);
  endtask

  task automatic setCfg(input logic [1:0] len, input logic pe, input logic [1:0] pt,
                        input logic s2, input logic wide);
    @(negedge clk);
    cfgLen = len; cfgParEn = pe; cfgParType = pt; cfgStop2 = s2; cfgWide = wide;
  endtask

  task automatic sendCheck(input string tag, input logic [7:0] b0, input logic [7:0] b1);
    logic [15:0] e, got;
    int nb;
    bit ok;
    e = expFrame(cfgLen, cfgParEn, cfgParType, cfgStop2, cfgWide, b0, b1, nb);
    rxFrame(nb, got, ok);
    check(ok && got == e, tag, got, e);
  endtask

  initial begin
    logic [7:0] b0, b1;
    logic [1:0] rl, rt;
    logic rp, rs, rw;
    bit stayHigh;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    check(txOut === 1'b1 && busy === 1'b0, "R1 reset state", {14'd0, busy, txOut}, 16'h0001);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(txOut === 1'b1 && busy === 1'b0 && fifoRead === 1'b0, "R1 idle no read",
          {13'd0, fifoRead, busy, txOut}, 16'h0001);

    // R3 all-zero config: 8N1
    pushByte(8'hA5);
    sendCheck("R3 default 8N1 frame", 8'hA5, 8'h00);
    waitIdle("R11 busy falls after stop");

    setCfg(2'd1, 1'b1, 2'd0, 1'b0, 1'b0);
    pushByte(8'hD3);
    sendCheck("R4 7-bit odd parity (bit7 excluded)", 8'hD3, 8'h00);
    waitIdle("R11 idle after 7O1");

    setCfg(2'd0, 1'b1, 2'd1, 1'b1, 1'b0);
    pushByte(8'h81);
    sendCheck("R5 8-bit even parity two stops", 8'h81, 8'h00);
    waitIdle("R5 idle after two stops");

    setCfg(2'd3, 1'b1, 2'd2, 1'b0, 1'b0);
    pushByte(8'h00);
    sendCheck("R4 mark parity len code 3", 8'h00, 8'h00);
    waitIdle("R3 idle");

    setCfg(2'd2, 1'b1, 2'd3, 1'b0, 1'b0);
    pushByte(8'hFF); pushByte(8'h3C);
    sendCheck("R6 9-bit single byte bit8=0, parity ignored", 8'hFF, 8'h00);
    sendCheck("R6 second byte is its own frame", 8'h3C, 8'h00);
    waitIdle("R6 idle");

    setCfg(2'd2, 1'b0, 2'd0, 1'b0, 1'b1);
    pushByte(8'h5A); pushByte(8'hFE);
    sendCheck("R7 wide pair upper bits ignored bit8=0", 8'h5A, 8'hFE);
    waitIdle("R7 idle");
    pushByte(8'h0F); pushByte(8'h01);
    sendCheck("R7 wide pair bit8=1", 8'h0F, 8'h01);
    waitIdle("R7 idle 2");

    // R8: one byte only, line must hold high
    pushByte(8'hC3);
    stayHigh = 1'b1;
    repeat (40) begin @(negedge clk); if (txOut !== 1'b1) stayHigh = 1'b0; end
    check(stayHigh && busy === 1'b1 && fifoQ.size() == 0, "R8 waits for second byte",
          {14'd0, busy, stayHigh}, 16'h0003);
    pushByte(8'h01);
    sendCheck("R8 frame after second byte", 8'hC3, 8'h01);
    waitIdle("R8 idle");

    setCfg(2'd0, 1'b0, 2'd0, 1'b0, 1'b1);
    pushByte(8'h96); pushByte(8'h69);
    sendCheck("R9 wide with 8 bits first byte", 8'h96, 8'h00);
    sendCheck("R9 wide with 8 bits second byte", 8'h69, 8'h00);
    waitIdle("R9 idle");

    // R10 back to back
    setCfg(2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    pushByte(8'h11); pushByte(8'h22); pushByte(8'h33);
    sendCheck("R10 back-to-back 1", 8'h11, 8'h00);
    sendCheck("R10 back-to-back 2", 8'h22, 8'h00);
    sendCheck("R10 back-to-back 3", 8'h33, 8'h00);
    waitIdle("R10 idle after burst");

    // random frames: R2/R3/R4/R5/R7
    for (int k = 0; k < 40; k++) begin
      rl = 2'($urandom_range(0, 3)); rp = 1'($urandom_range(0, 1));
      rt = 2'($urandom_range(0, 3)); rs = 1'($urandom_range(0, 1));
      rw = 1'($urandom_range(0, 1));
      b0 = 8'($urandom_range(0, 255)); b1 = 8'($urandom_range(0, 255));
      setCfg(rl, rp, rt, rs, rw);
      pushByte(b0);
      if (rl == 2'd2 && rw) pushByte(b1);
      sendCheck("R2 random frame", b0, b1);
      waitIdle("R11 random idle");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule